// File: doc/BRIEF.md
# Fifteen-Source Prioritised Interrupt Controller

The block gathers fifteen interrupt request lines into one pending vector and presents the most urgent of them to a processor. The lines are numbered 1 to 15, and each number does three jobs. It is the bit position of the line in every register of the block. It is the priority of the line, so a larger number is more urgent. It also sets the trap type reported with the request, which is the number plus 0x10. Software blocks individual lines with a mask vector. Lines that are pending and not masked compete, and the winner's number comes out as a 4-bit level, with 0 meaning that nothing is requested.

A rising edge on a line records a request. Software removes requests through a write-one-to-clear port. Software can also create requests through a write-one-to-set port, but only while a test-enable bit is set. When the processor accepts an interrupt it returns the accepted level on an acknowledge port, and that pending bit is then dropped. A simple write strobe with a combinational read path gives access to the registers. In a typical system the general-purpose timer drives line 12, the real-time clock drives line 13 and the watchdog timeout drives line 15.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending vector, the mask vector and the test-enable bit are all zero, and `irq_level` and `irq_trap` read 0.
- R2: When a source line goes from 0 to 1 between two clock edges, its pending bit is set at the second of those edges. A line that stays high does not set its bit again after the bit has been cleared.
- R3: `irq_level` equals the highest bit number n (1 to 15) for which pending[n]=1 and mask[n]=0, or 0 when no such bit exists. It follows the registers in the same cycle.
- R4: A mask bit of 1 removes its line from the competition, but the pending bit is still recorded and can be read back. The mask register at offset 0x4C can be written and read, and it holds bits 15:1.
- R5: Writing to the clear port (offset 0x50) clears every pending bit whose data bit is 1 at that clock edge. Data bits of 0 leave their pending bits unchanged.
- R6: Writing to the force port (offset 0x54) sets every pending bit whose data bit is 1, but only while the test-enable bit (bit 19 of the test register at offset 0xD0) is 1. While that bit is 0, the write leaves the pending vector unchanged.
- R7: When `ack_valid` is high with `ack_level`=n (1 to 15), pending bit n is cleared at that clock edge. An `ack_level` of 0 has no effect.
- R8: When a set (edge or force) and a clear (clear port or acknowledge) hit the same pending bit at the same edge, the bit ends up set.
- R9: Bit 0 of every register reads 0, and source line 0 never sets anything. The pending vector reads at offset 0x48, and writes there are ignored. The clear and force ports, and unmapped offsets, read as 0. The test register reads back only bit 19.
- R10: `irq_trap` equals `irq_level` + 0x10 when `irq_level` is not 0, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 16 | Request lines, bit n is line n; bit 0 is ignored |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ack_valid | input | 1 | Processor accepts an interrupt |
| ack_level | input | 4 | Level being accepted |
| irq_level | output | 4 | Winning level, 0 when no request |
| irq_trap | output | 8 | Trap type of the winning level, 0 when no request |

## Verification
The block holds only a few bits of state: the previous source levels, the pending vector, the mask and the test-enable bit. A wrong pending or mask bit therefore shows on `irq_level` in the same cycle as soon as that bit is the most urgent unmasked one, and on a read of offset 0x48 or 0x4C at any time. A lost edge, or an extra one, appears one clock after the source toggles. A clear, force or acknowledge that hits the wrong bit is exposed by reading the pending vector back straight after the write. The directed scenarios aim at the points where two events meet: a set and a clear of the same bit at one edge, a force with the test bit off, a masked line that outranks the current winner, and a line held high across a clear.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  // byte offsets that software depends on
  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_FORCE = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_TEST  = 8'hD0;

  localparam int unsigned TEST_EN_BIT = 19;
  localparam logic [7:0]  TRAP_BASE   = 8'h10;
endpackage

// File: rtl/irq_edge_cap.sv
module irq_edge_cap #(
  parameter int unsigned VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] line_in,
  output logic [VEC_W-1:0] rise_out
);
  logic [VEC_W-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_in;
  end

  assign rise_out = line_in & ~line_q;
endmodule

// File: rtl/irq_pend_store.sv
module irq_pend_store #(
  parameter int unsigned VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] set_vec,
  input  logic [VEC_W-1:0] clr_vec,
  output logic [VEC_W-1:0] pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | set_vec;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));
  // R5
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));
  // R6
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned VEC_W = 16,
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] req,
  output logic [LVL_W-1:0] lvl
);
  function automatic logic [LVL_W-1:0] highest_set(input logic [VEC_W-1:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 1; i < VEC_W; i++)
      if (v[i]) r = LVL_W'(i);
    return r;
  endfunction

  assign lvl = highest_set(req);

  // R3
  level_is_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != '0) |-> (req[lvl] && ((req >> lvl) == VEC_W'(1))));
  // R3
  idle_means_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == '0) |-> ((req >> 1) == '0));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned SRC_CNT = 15
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [SRC_CNT:0]                  src_in,
  input  logic                              bus_wr_en,
  input  logic [irq_prio_pkg::ADDR_W-1:0]   bus_addr,
  input  logic [irq_prio_pkg::DATA_W-1:0]   bus_wdata,
  output logic [irq_prio_pkg::DATA_W-1:0]   bus_rdata,
  input  logic                              ack_valid,
  input  logic [$clog2(SRC_CNT+1)-1:0]      ack_level,
  output logic [$clog2(SRC_CNT+1)-1:0]      irq_level,
  output logic [7:0]                        irq_trap
);
  localparam int unsigned VEC_W = SRC_CNT + 1;
  localparam int unsigned LVL_W = $clog2(SRC_CNT + 1);
  localparam logic [VEC_W-1:0] LIVE = {{SRC_CNT{1'b1}}, 1'b0};

  function automatic logic [VEC_W-1:0] level_to_vec(input logic [LVL_W-1:0] l);
    logic [VEC_W-1:0] v;
    v = '0;
    for (int i = 1; i < VEC_W; i++)
      if (l == LVL_W'(i)) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [7:0] trap_of(input logic [LVL_W-1:0] l);
    return (l == '0) ? 8'h00 : (TRAP_BASE + 8'(l));
  endfunction

  logic [VEC_W-1:0] rise_vec, pend_q, mask_q, req_vec;
  logic [VEC_W-1:0] set_vec, clr_vec, ack_vec, force_vec, wclr_vec;
  logic             test_en_q;
  logic             wr_mask, wr_clr, wr_force, wr_test;
  logic             unused_wdata;

  assign wr_mask  = bus_wr_en && (bus_addr == OFS_MASK);
  assign wr_clr   = bus_wr_en && (bus_addr == OFS_CLR);
  assign wr_force = bus_wr_en && (bus_addr == OFS_FORCE);
  assign wr_test  = bus_wr_en && (bus_addr == OFS_TEST);
  assign unused_wdata = ^bus_wdata;

  irq_edge_cap #(.VEC_W(VEC_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .line_in(src_in), .rise_out(rise_vec)
  );

  assign ack_vec   = ack_valid ? level_to_vec(ack_level) : '0;
  assign force_vec = (wr_force && test_en_q) ? bus_wdata[VEC_W-1:0] : '0;
  assign wclr_vec  = wr_clr ? bus_wdata[VEC_W-1:0] : '0;
  assign set_vec   = (rise_vec | force_vec) & LIVE;
  assign clr_vec   = (wclr_vec | ack_vec) & LIVE;

  irq_pend_store #(.VEC_W(VEC_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .pend_q(pend_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      test_en_q <= 1'b0;
    end else begin
      if (wr_mask) mask_q    <= bus_wdata[VEC_W-1:0] & LIVE;
      if (wr_test) test_en_q <= bus_wdata[TEST_EN_BIT];
    end
  end

  assign req_vec = pend_q & ~mask_q;

  irq_prio_pick #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(req_vec), .lvl(irq_level)
  );

  assign irq_trap = trap_of(irq_level);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_PEND: bus_rdata[VEC_W-1:0] = pend_q;
      OFS_MASK: bus_rdata[VEC_W-1:0] = mask_q;
      OFS_TEST: bus_rdata[TEST_EN_BIT] = test_en_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R6
  force_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_force && !test_en_q && ((rise_vec & LIVE) == '0)) |=> ((pend_q & ~$past(pend_q)) == '0));
  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && (ack_level != '0) && ((set_vec & ack_vec) == '0)) |=> !pend_q[$past(ack_level)]);
  // R4
  masked_never_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> !mask_q[irq_level]);
  // R9
  bit0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[0] && !mask_q[0]);
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_in = '0;
  logic        bus_wr_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_level = '0;
  logic [3:0]  irq_level;
  logic [7:0]  irq_trap;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr_en(bus_wr_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_valid(ack_valid), .ack_level(ack_level), .irq_level(irq_level),
    .irq_trap(irq_trap)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock, then settle just after the edge
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr_en = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic raise(input int n);
    @(negedge clk);
    src_in[n] = 1'b1;
    tick();
  endtask

  task automatic drop_all();
    @(negedge clk);
    src_in = '0;
    tick();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h48, d); chk("R1 pending", d, 0);
    rd(8'h4C, d); chk("R1 mask", d, 0);
    rd(8'hD0, d); chk("R1 test", d, 0);
    chk("R1 level", irq_level, 0);
    chk("R1 trap", irq_trap, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    raise(5);
    rd(8'h48, d); chk("R2 edge sets bit5", d, 32'h20);
    chk("R3 level 5", irq_level, 5);
    chk("R10 trap 0x15", irq_trap, 8'h15);
    wr(8'h50, 32'h20);
    tick(); tick();
    rd(8'h48, d); chk("R2 held line no reset after clear", d, 0);
    chk("R5 level idle", irq_level, 0);
    drop_all();
  endtask

  task automatic t_clear();
    logic [31:0] d;
    raise(3); raise(7);
    wr(8'h50, 32'h0);
    rd(8'h48, d); chk("R5 zero write keeps", d, 32'h88);
    wr(8'h50, 32'h8);
    rd(8'h48, d); chk("R5 clear bit3 only", d, 32'h80);
    drop_all();
  endtask

  task automatic t_priority();
    logic [31:0] d;
    @(negedge clk); src_in[12] = 1'b1; src_in[15] = 1'b1; tick();
    chk("R3 highest wins", irq_level, 15);
    chk("R10 trap 0x1F", irq_trap, 8'h1F);
    wr(8'h4C, 32'h8000);
    chk("R4 masked 15 gives 12", irq_level, 12);
    rd(8'h48, d); chk("R4 masked still pending", d, 32'h9080);
    rd(8'h4C, d); chk("R4 mask readback", d, 32'h8000);
    wr(8'h4C, 32'h0);
    chk("R4 unmask restores 15", irq_level, 15);
    drop_all();
  endtask

  task automatic t_ack();
    logic [31:0] d;
    @(negedge clk); ack_valid = 1'b1; ack_level = 4'd15; tick();
    ack_valid = 1'b0;
    chk("R7 ack 15 -> 12", irq_level, 12);
    @(negedge clk); ack_valid = 1'b1; ack_level = 4'd0; tick();
    ack_valid = 1'b0;
    rd(8'h48, d); chk("R7 ack 0 no effect", d, 32'h1080);
    @(negedge clk); ack_valid = 1'b1; ack_level = 4'd12; tick();
    @(negedge clk); ack_level = 4'd7; tick();
    ack_valid = 1'b0;
    chk("R7 all acked", irq_level, 0);
  endtask

  task automatic t_force();
    logic [31:0] d;
    wr(8'h54, 32'h200);
    rd(8'h48, d); chk("R6 force locked", d, 0);
    wr(8'hD0, 32'hFFFF_FFFF);
    rd(8'hD0, d); chk("R9 test reads bit19 only", d, 32'h80000);
    wr(8'h54, 32'h200);
    rd(8'h48, d); chk("R6 force bit9", d, 32'h200);
    wr(8'h54, 32'h1);
    rd(8'h48, d); chk("R9 force bit0 ignored", d, 32'h200);
    wr(8'hD0, 32'h0);
    wr(8'h50, 32'hFFFF);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk);
    src_in[4] = 1'b1; bus_wr_en = 1'b1; bus_addr = 8'h50; bus_wdata = 32'h10;
    tick();
    bus_wr_en = 1'b0;
    rd(8'h48, d); chk("R8 edge beats clear", d, 32'h10);
    drop_all();
    @(negedge clk);
    src_in[4] = 1'b1; ack_valid = 1'b1; ack_level = 4'd4;
    tick();
    ack_valid = 1'b0;
    rd(8'h48, d); chk("R8 edge beats ack", d, 32'h10);
    drop_all();
    wr(8'h50, 32'h10);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h4C, d); chk("R9 mask bit0 zero", d, 32'hFFFE);
    wr(8'h4C, 32'h0);
    raise(0);
    rd(8'h48, d); chk("R9 line0 ignored", d, 0);
    drop_all();
    raise(1);
    rd(8'h50, d); chk("R9 clear reads 0", d, 0);
    rd(8'h54, d); chk("R9 force reads 0", d, 0);
    rd(8'h00, d); chk("R9 unmapped reads 0", d, 0);
    wr(8'h48, 32'h0);
    rd(8'h48, d); chk("R9 pending write ignored", d, 32'h2);
    chk("R3 lowest level 1", irq_level, 1);
    chk("R10 trap 0x11", irq_trap, 8'h11);
    drop_all();
  endtask

  initial begin
    #(CLK_P*3);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_edge();
    t_clear();
    t_priority();
    t_ack();
    t_force();
    t_collide();
    t_reserved();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_P*20000);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule